// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank single-data-rate SDRAM and takes the memory from power-on to a usable state. After reset it drives the command pins to NOP and holds the clock-enable and data-mask pins high for a programmable start-up wait. It then precharges both banks, programs the mode register from a configuration word, and issues the required auto-refresh commands. The refreshes go either before or after the mode register set, as a parameter selects.

Every later command waits out its own recovery time, given in clock cycles by a parameter. When the last recovery time has run out, the block raises a ready flag and releases the data mask. The flag stays high until the next synchronous reset, which restarts the whole sequence from the wait. All pin outputs come straight from registers.

Top module: `sdram_boot_seq`

## Requirements
- R1: While `rst` is high, the outputs after each clock edge are NOP, `sd_cke`=1, `sd_dqm`=1, `sd_addr`=0 and `init_done`=0. A reset at any point, including after ready, restarts the sequence from the start-up wait.
- R2: After reset is released, the command pins show NOP for exactly `WAIT_CYC` cycles. The first command appears on the pins after the `WAIT_CYC`+1-th clock edge.
- R3: Command encodings on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} are NOP=0111, precharge=0010, auto-refresh=0001 and mode register set=0000.
- R4: The first command is a precharge with address bit 10 set and every other address bit clear, so that it covers all banks.
- R5: The mode register set carries the mode word on the address pins: bits 2:0 are the burst-length code, bit 3 is the burst type, bits 6:4 are the CAS-latency code, bits 8:7 are 00, bit 9 is the write-burst mode (1 = single write), and all higher bits are 0.
- R6: The next command follows a precharge exactly `T_RP` cycles later.
- R7: The next command (or ready) follows the mode register set exactly `T_MRD` cycles later, and at least one NOP cycle comes in between (`T_MRD` >= 2).
- R8: Exactly `N_REF` auto-refreshes are issued, each `T_RC` cycles apart from what follows it. With `REF_FIRST`=0 they all come after the mode register set; with `REF_FIRST`=1 they all come between the precharge and the mode register set.
- R9: `init_done` rises exactly one recovery time after the final command and then stays high. `sd_dqm` goes low in the same cycle and stays low, and only NOP is driven afterwards.
- R10: No command other than NOP, precharge, auto-refresh or mode register set is ever driven; in particular no activate.
- R11: `sd_cke` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| cfg_burst_len | input | 3 | Burst-length code for the mode word |
| cfg_burst_type | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | CAS-latency code for the mode word |
| cfg_wr_single | input | 1 | Write burst mode: 0 burst writes, 1 single writes |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins (mode word or all-bank flag) |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_dqm | output | 1 | Data mask, high until ready |
| init_done | output | 1 | Sticky ready flag |

## Verification
The sequence runs on two instances side by side, one with refreshes after the mode set and one with them before, so a single run tells the two orderings apart. Three configuration words with different bit patterns in every field (all zero, mixed, mostly ones) show whether each field lands at its own address bit. Resetting in the middle of the command phase and again after ready shows whether the block restarts from the wait and drops the flag. Each event is timestamped, so off-by-one errors in the wait or in any recovery counter show up as a wrong cycle.

// File: rtl/sdram_boot_pkg.sv
`timescale 1ns/1ps
package sdram_boot_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE,
    ST_PRE_W,
    ST_REF,
    ST_REF_W,
    ST_MRS,
    ST_MRS_W,
    ST_DONE
  } boot_state_e;

  // Address bit that selects all banks on a precharge
  localparam int ALL_BANK_BIT = 10;

endpackage

// File: rtl/boot_timer.sv
`timescale 1ns/1ps
// Loadable down-counter shared by the start-up wait and all recovery windows.
module boot_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= W'(RST_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/boot_mode_word.sv
`timescale 1ns/1ps
// Packs the configuration fields into the address-pin mode word.
module boot_mode_word #(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        burst_len,
  input  logic              burst_type,
  input  logic [2:0]        cas_lat,
  input  logic              wr_single,
  output logic [ADDR_W-1:0] word
);
  always_comb begin
    word      = '0;
    word[2:0] = burst_len;
    word[3]   = burst_type;
    word[6:4] = cas_lat;
    word[8:7] = 2'b00;      // normal operation, no test mode
    word[9]   = wr_single;
  end
endmodule

// File: rtl/boot_pin_drive.sv
`timescale 1ns/1ps
// Output register stage for every pin the sequencer drives.
module boot_pin_drive
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  sd_cmd_e           cmd_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              ready_d,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              cke,
  output logic              dqm,
  output logic              ready
);
  sd_cmd_e cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_NOP;
      addr  <= '0;
      cke   <= 1'b1;
      dqm   <= 1'b1;
      ready <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      addr  <= addr_d;
      cke   <= 1'b1;
      dqm   <= ~ready_d;
      ready <= ready_d;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
endmodule

// File: rtl/sdram_boot_seq.sv
`timescale 1ns/1ps
// Power-up sequencer: wait, precharge all, mode set and refreshes, then ready.
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WAIT_CYC  = 10000,  // start-up wait in cycles (>= 1)
  parameter int T_RP      = 3,      // precharge recovery (>= 2)
  parameter int T_RC      = 7,      // refresh cycle time (>= 2)
  parameter int T_MRD     = 2,      // mode-set recovery (>= 2)
  parameter int N_REF     = 8,      // number of refreshes (>= 1)
  parameter bit REF_FIRST = 1'b0    // 1: refreshes before the mode set
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_wr_single,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic              init_done
);
  localparam int TMAX_A = (WAIT_CYC > T_RP) ? WAIT_CYC : T_RP;
  localparam int TMAX_B = (T_RC > T_MRD) ? T_RC : T_MRD;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int RCW    = $clog2(N_REF + 1);

  boot_state_e       st_q, st_d;
  logic              t_load, t_zero;
  logic [TW-1:0]     t_val;
  logic [RCW-1:0]    ref_cnt_q;
  logic              ref_inc;
  logic [ADDR_W-1:0] mode_word;
  sd_cmd_e           cmd_d;
  logic [ADDR_W-1:0] addr_d;

  boot_timer #(.W(TW), .RST_VAL(WAIT_CYC - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_zero)
  );

  boot_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .burst_len  (cfg_burst_len),
    .burst_type (cfg_burst_type),
    .cas_lat    (cfg_cas_lat),
    .wr_single  (cfg_wr_single),
    .word       (mode_word)
  );

  // Sequencing
  always_comb begin
    st_d    = st_q;
    t_load  = 1'b0;
    t_val   = '0;
    ref_inc = 1'b0;
    unique case (st_q)
      ST_WAIT:  if (t_zero) st_d = ST_PRE;
      ST_PRE: begin
        t_load = 1'b1;
        t_val  = TW'(T_RP - 2);
        st_d   = ST_PRE_W;
      end
      ST_PRE_W: if (t_zero) st_d = REF_FIRST ? ST_REF : ST_MRS;
      ST_REF: begin
        t_load  = 1'b1;
        t_val   = TW'(T_RC - 2);
        ref_inc = 1'b1;
        st_d    = ST_REF_W;
      end
      ST_REF_W: begin
        if (t_zero) begin
          if (ref_cnt_q == RCW'(N_REF)) st_d = REF_FIRST ? ST_MRS : ST_DONE;
          else                          st_d = ST_REF;
        end
      end
      ST_MRS: begin
        t_load = 1'b1;
        t_val  = TW'(T_MRD - 2);
        st_d   = ST_MRS_W;
      end
      ST_MRS_W: if (t_zero) st_d = REF_FIRST ? ST_DONE : ST_REF;
      ST_DONE:  st_d = ST_DONE;
      default:  st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_WAIT;
      ref_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (ref_inc) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  // Command and address for the state being left
  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    unique case (st_q)
      ST_PRE: begin
        cmd_d                = CMD_PRE;
        addr_d[ALL_BANK_BIT] = 1'b1;
      end
      ST_REF: cmd_d = CMD_REF;
      ST_MRS: begin
        cmd_d  = CMD_MRS;
        addr_d = mode_word;
      end
      default: ;
    endcase
  end

  boot_pin_drive #(.ADDR_W(ADDR_W)) u_pins (
    .clk     (clk),
    .rst     (rst),
    .cmd_d   (cmd_d),
    .addr_d  (addr_d),
    .ready_d (st_q == ST_DONE),
    .cs_n    (sd_cs_n),
    .ras_n   (sd_ras_n),
    .cas_n   (sd_cas_n),
    .we_n    (sd_we_n),
    .addr    (sd_addr),
    .cke     (sd_cke),
    .dqm     (sd_dqm),
    .ready   (init_done)
  );
endmodule

// File: rtl/sdram_boot_seq_chk.sv
`timescale 1ns/1ps
module sdram_boot_seq_chk #(
  parameter int ADDR_W   = 12,
  parameter int WAIT_CYC = 10000,
  parameter int N_REF    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              sd_cke,
  input logic              sd_dqm,
  input logic              init_done
);
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  logic is_nop, is_pre, is_ref, is_mrs;
  assign is_nop = (cmd == 4'b0111);
  assign is_pre = (cmd == 4'b0010);
  assign is_ref = (cmd == 4'b0001);
  assign is_mrs = (cmd == 4'b0000);

  int  since_rst;
  int  refs_seen;
  logic pre_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= 0;
      refs_seen <= 0;
      pre_seen  <= 1'b0;
    end else begin
      if (since_rst < WAIT_CYC) since_rst <= since_rst + 1;
      if (is_ref && refs_seen < N_REF + 1) refs_seen <= refs_seen + 1;
      if (is_pre) pre_seen <= 1'b1;
    end
  end

  // R2: nothing but NOP before the start-up wait has elapsed
  a_r2_wait_nop: assert property (@(posedge clk) disable iff (rst)
    !is_nop |-> since_rst >= WAIT_CYC);

  // R2: data mask high until ready
  a_r2_dqm_high: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> sd_dqm);

  // R4: precharge covers all banks
  a_r4_pre_all: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> sd_addr == (ADDR_W'(1) << 10));

  // R4: mode set only once banks have been precharged
  a_r4_pre_before_mrs: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> pre_seen);

  // R5: reserved mode bits clear
  a_r5_mode_reserved: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (sd_addr[8:7] == 2'b00) && ((sd_addr >> 10) == '0));

  // R7: a NOP follows the mode set
  a_r7_nop_after_mrs: assert property (@(posedge clk) disable iff (rst)
    is_mrs |=> is_nop);

  // R8: all refreshes issued before ready
  a_r8_ref_count: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> refs_seen == N_REF);

  // R9: ready is sticky, mask released, bus idle
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    init_done |-> is_nop && !sd_dqm);

  // R10: only the four legal commands
  a_r10_legal_cmd: assert property (@(posedge clk) disable iff (rst)
    is_nop || is_pre || is_ref || is_mrs);

  // R11: clock enable always high
  a_r11_cke_high: assert property (@(posedge clk) disable iff (rst)
    sd_cke);
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
  .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .N_REF(N_REF)
) u_chk (
  .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
  .sd_cke(sd_cke), .sd_dqm(sd_dqm), .init_done(init_done)
);

// File: tb/sdram_boot_seq_bench.sv
`timescale 1ns/1ps
module sdram_boot_seq_bench;
  localparam int ADDR_W   = 12;
  localparam int WAIT_CYC = 40;
  localparam int T_RP     = 3;
  localparam int T_RC     = 6;
  localparam int T_MRD    = 2;
  localparam int N_REF    = 8;
  localparam int N_EV     = N_REF + 2;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_bl = '0;
  logic       cfg_bt = 1'b0;
  logic [2:0] cfg_cl = '0;
  logic       cfg_wb = 1'b0;

  always #10 clk = ~clk;

  logic [3:0]        cmd_w  [2];
  logic [ADDR_W-1:0] addr_w [2];
  logic              cke_w  [2];
  logic              dqm_w  [2];
  logic              done_w [2];

  sdram_boot_seq #(
    .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .N_REF(N_REF), .REF_FIRST(1'b0)
  ) u_sdram_boot_seq (
    .clk(clk), .rst(rst), .cfg_burst_len(cfg_bl), .cfg_burst_type(cfg_bt),
    .cfg_cas_lat(cfg_cl), .cfg_wr_single(cfg_wb),
    .sd_cs_n(cmd_w[0][3]), .sd_ras_n(cmd_w[0][2]), .sd_cas_n(cmd_w[0][1]),
    .sd_we_n(cmd_w[0][0]), .sd_addr(addr_w[0]), .sd_cke(cke_w[0]),
    .sd_dqm(dqm_w[0]), .init_done(done_w[0])
  );

  sdram_boot_seq #(
    .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .N_REF(N_REF), .REF_FIRST(1'b1)
  ) u_sdram_boot_seq_reffirst (
    .clk(clk), .rst(rst), .cfg_burst_len(cfg_bl), .cfg_burst_type(cfg_bt),
    .cfg_cas_lat(cfg_cl), .cfg_wr_single(cfg_wb),
    .sd_cs_n(cmd_w[1][3]), .sd_ras_n(cmd_w[1][2]), .sd_cas_n(cmd_w[1][1]),
    .sd_we_n(cmd_w[1][0]), .sd_addr(addr_w[1]), .sd_cke(cke_w[1]),
    .sd_dqm(dqm_w[1]), .init_done(done_w[1])
  );

  int checks = 0;
  int errors = 0;

  logic [3:0]        ev_cmd  [2][32];
  logic [ADDR_W-1:0] ev_addr [2][32];
  int                ev_cyc  [2][32];
  int                ev_n    [2];
  int                done_cyc[2];
  int                bad_cmd [2];
  int                bad_dqm [2];
  int                bad_cke [2];
  int                done_drop[2];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      // R1: reset values
      check(cmd_w[i] == NOP, "R1", "cmd during reset", cmd_w[i], NOP);
      check(cke_w[i] && dqm_w[i] && addr_w[i] == '0, "R1", "cke/dqm/addr during reset",
            {cke_w[i], dqm_w[i], (addr_w[i] == '0)}, 3'b111);
      check(!done_w[i], "R1", "done during reset", done_w[i], 0);
    end
    rst = 1'b0;
  endtask

  // Records every non-NOP command after reset release, stamped by edge count.
  task automatic record_run(input int limit);
    int stop_at = -1;
    for (int i = 0; i < 2; i++) begin
      ev_n[i] = 0; done_cyc[i] = -1; bad_cmd[i] = 0;
      bad_dqm[i] = 0; bad_cke[i] = 0; done_drop[i] = 0;
    end
    for (int c = 1; c <= limit; c++) begin
      @(posedge clk); #1;
      for (int i = 0; i < 2; i++) begin
        if (cmd_w[i] != NOP && ev_n[i] < 32) begin
          ev_cmd[i][ev_n[i]]  = cmd_w[i];
          ev_addr[i][ev_n[i]] = addr_w[i];
          ev_cyc[i][ev_n[i]]  = c;
          ev_n[i]++;
        end
        if (!(cmd_w[i] inside {NOP, PRE, REF, MRS})) bad_cmd[i]++;
        if (!cke_w[i]) bad_cke[i]++;
        if (done_w[i] && done_cyc[i] < 0) done_cyc[i] = c;
        if (done_cyc[i] >= 0 && !done_w[i]) done_drop[i]++;
        if (done_w[i] == dqm_w[i]) bad_dqm[i]++;
      end
      if (stop_at < 0 && done_cyc[0] >= 0 && done_cyc[1] >= 0)
        stop_at = c + 20;
      if (c == stop_at) break;
    end
  endtask

  function automatic int gap_of(input logic [3:0] cmd);
    if (cmd == PRE) return T_RP;
    if (cmd == REF) return T_RC;
    return T_MRD;
  endfunction

  task automatic check_run(input string tag);
    logic [3:0]        exp_cmd[N_EV];
    logic [ADDR_W-1:0] mode;
    int                t;
    mode = '0;
    mode[2:0] = cfg_bl; mode[3] = cfg_bt; mode[6:4] = cfg_cl; mode[9] = cfg_wb;
    for (int i = 0; i < 2; i++) begin
      exp_cmd[0] = PRE;
      for (int k = 1; k < N_EV; k++)
        exp_cmd[k] = (i == 0) ? ((k == 1) ? MRS : REF) : ((k == N_EV - 1) ? MRS : REF);
      // R8: count of commands (refresh count plus precharge and mode set)
      check(ev_n[i] == N_EV, "R8", {tag, " command count"}, ev_n[i], N_EV);
      t = WAIT_CYC + 1;  // R2: first command after the wait
      for (int k = 0; k < N_EV && k < ev_n[i]; k++) begin
        check(ev_cmd[i][k] == exp_cmd[k], "R3/R8", {tag, " command code"},
              ev_cmd[i][k], exp_cmd[k]);
        if (k == 0)
          check(ev_cyc[i][k] == t, "R2", {tag, " first command cycle"}, ev_cyc[i][k], t);
        else if (exp_cmd[k - 1] == PRE)
          check(ev_cyc[i][k] == t, "R6", {tag, " gap after precharge"}, ev_cyc[i][k], t);
        else if (exp_cmd[k - 1] == MRS)
          check(ev_cyc[i][k] == t, "R7", {tag, " gap after mode set"}, ev_cyc[i][k], t);
        else
          check(ev_cyc[i][k] == t, "R8", {tag, " gap after refresh"}, ev_cyc[i][k], t);
        if (exp_cmd[k] == PRE)
          check(ev_addr[i][k] == (ADDR_W'(1) << 10), "R4", {tag, " precharge address"},
                ev_addr[i][k], ADDR_W'(1) << 10);
        if (exp_cmd[k] == MRS)
          check(ev_addr[i][k] == mode, "R5", {tag, " mode word"}, ev_addr[i][k], mode);
        t = ev_cyc[i][k] + gap_of(exp_cmd[k]);
      end
      check(done_cyc[i] == t, (i == 0) ? "R8" : "R7", {tag, " ready cycle"}, done_cyc[i], t);
      check(done_drop[i] == 0, "R9", {tag, " ready stays high"}, done_drop[i], 0);
      check(bad_dqm[i] == 0, "R9", {tag, " dqm high until ready then low"}, bad_dqm[i], 0);
      check(bad_cmd[i] == 0, "R10", {tag, " illegal commands"}, bad_cmd[i], 0);
      check(bad_cke[i] == 0, "R11", {tag, " cke low cycles"}, bad_cke[i], 0);
    end
  endtask

  task automatic set_cfg(input logic [2:0] bl, input logic bt,
                         input logic [2:0] cl, input logic wb);
    cfg_bl = bl; cfg_bt = bt; cfg_cl = cl; cfg_wb = wb;
  endtask

  task automatic t_mixed_cfg();
    set_cfg(3'b011, 1'b1, 3'b010, 1'b0);
    apply_reset();
    record_run(400);
    check_run("mixed cfg");
  endtask

  task automatic t_ones_cfg();
    set_cfg(3'b111, 1'b0, 3'b011, 1'b1);
    apply_reset();
    record_run(400);
    check_run("ones cfg");
  endtask

  task automatic t_zero_cfg_after_done_reset();
    set_cfg(3'b000, 1'b0, 3'b000, 1'b0);
    // R1: reset after ready drops the flag and restarts
    apply_reset();
    record_run(400);
    check_run("zero cfg");
  endtask

  task automatic t_restart_mid();
    set_cfg(3'b010, 1'b1, 3'b110, 1'b1);
    apply_reset();
    repeat (WAIT_CYC + 8) @(posedge clk);
    // R1: restart in the middle of the command phase
    apply_reset();
    record_run(400);
    check_run("restart");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_mixed_cfg();
    t_ones_cfg();
    t_zero_cfg_after_done_reset();
    t_restart_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule